// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned W-bit operands over W clock cycles. It uses one adder of the operand width. The multiplicand is captured into a register that never shifts. The multiplier operand is loaded into the low half of a double-width product register, and the high half is cleared. On each cycle the block looks at bit 0 of the product register. If that bit is set, the multiplicand is added to the high half. The whole register then moves one place to the right, and the adder's carry-out enters the top bit.

A caller asserts a start pulse together with both operands while the block is idle. The busy flag then stays high for exactly W cycles. A one-cycle done pulse marks the cycle in which the full product is valid. The product stays on the output until the next accepted start, and start requests that arrive while busy are ignored.

Top module: `seqmul_top`

## Requirements
- R1: When start_i is high and busy_o is low at a rising edge, the operands are captured. From the next cycle busy_o is 1 and product_o equals the multiplier operand zero-extended to 2W bits, with the high W bits cleared.
- R2: When done_o is high, product_o equals the unsigned product mcand_i × mplier_i of the operands captured at the accepted start.
- R3: busy_o stays high for exactly W cycles after acceptance. done_o rises in the cycle that begins W rising edges after the accepting edge.
- R4: done_o is high for a single cycle, and busy_o is low whenever done_o is high.
- R5: start_i and operand changes while busy_o is high are ignored and do not alter the result.
- R6: While idle with start_i low, product_o holds its last value regardless of operand inputs.
- R7: Synchronous active-high reset clears product_o, busy_o and done_o, including in the middle of an operation.
- R8: No carry is lost. All-ones operands give (2^W−1)², and the top product bit is correct.
- R9: A start presented in the done cycle is accepted, because busy_o is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a multiplication |
| mcand_i | input | W | Multiplicand operand |
| mplier_i | input | W | Multiplier operand |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle pulse when the product is valid |
| product_o | output | 2W | Product register contents |

## Verification
The loaded value is due one edge after the accepting edge. done_o and the final product are due W edges after that. done_o must be low again one edge later. The bench drives inputs on falling edges and samples on falling edges. It counts exactly one edge for the load, W − 1 edges to confirm that busy_o is still high, and one more edge for done_o. A small instance with W = 5 is swept over every operand pair, and a 32-bit instance covers corner operands, back-to-back starts, start requests while busy, and a reset during an operation.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef struct packed {
        logic load;   // accept operands this edge
        logic step;   // perform one add/shift this edge
        logic last;   // this step is the final one
    } seq_ctl_t;

    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
    import seqmul_pkg::*;
#(
    parameter int unsigned ITER = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    output seq_ctl_t ctl_o,
    output logic     busy_o,
    output logic     done_o
);
    localparam int unsigned CW = cnt_bits(ITER);
    localparam logic [CW-1:0] LAST_IDX = CW'(ITER - 1);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    always_comb begin
        ctl_o.load = (phase_q == PH_IDLE) && start_i;
        ctl_o.step = (phase_q == PH_RUN);
        ctl_o.last = ctl_o.step && (cnt_q == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= ctl_o.last;
            if (ctl_o.load) begin
                phase_q <= PH_RUN;
                cnt_q   <= '0;
            end else if (ctl_o.step) begin
                if (ctl_o.last) begin
                    phase_q <= PH_IDLE;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign busy_o = (phase_q == PH_RUN);
    assign done_o = done_q;

endmodule

// File: rtl/mul_step.sv
module mul_step #(
    parameter int unsigned W = 32
) (
    input  logic [2*W-1:0] prod_i,
    input  logic [W-1:0]   mcand_i,
    output logic [2*W-1:0] prod_o
);
    logic [W-1:0] addend;
    logic [W:0]   sum;

    always_comb begin
        addend = prod_i[0] ? mcand_i : '0;
        sum    = {1'b0, prod_i[2*W-1:W]} + {1'b0, addend};
        // carry lands in the top bit, low half drops its tested bit
        prod_o = {sum, prod_i[W-1:1]};
    end

endmodule

// File: rtl/seqmul_top.sv
module seqmul_top
    import seqmul_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplier_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*W-1:0] product_o
);
    localparam int unsigned PW = 2 * W;

    seq_ctl_t       ctl;
    logic [W-1:0]   mcand_q;
    logic [PW-1:0]  prod_q;
    logic [PW-1:0]  prod_next;

    mul_ctrl #(.ITER(W)) ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .ctl_o   (ctl),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    mul_step #(.W(W)) step_i (
        .prod_i  (prod_q),
        .mcand_i (mcand_q),
        .prod_o  (prod_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (ctl.load) begin
            mcand_q <= mcand_i;
            prod_q  <= {{W{1'b0}}, mplier_i};
        end else if (ctl.step) begin
            prod_q <= prod_next;
        end
    end

    assign product_o = prod_q;

endmodule

// File: rtl/mul_chk.sv
module mul_chk #(
    parameter int unsigned W = 32
) (
    input logic           clk,
    input logic           rst,
    input logic           start_i,
    input logic [W-1:0]   mcand_i,
    input logic [W-1:0]   mplier_i,
    input logic           busy_o,
    input logic           done_o,
    input logic [2*W-1:0] product_o
);
    localparam int unsigned CNW = $clog2(W + 1) + 1;

    logic [2*W-1:0] exp_q;
    logic [CNW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q   <= '0;
            run_cnt <= '0;
        end else if (start_i && !busy_o) begin
            exp_q   <= {{W{1'b0}}, mcand_i} * {{W{1'b0}}, mplier_i};
            run_cnt <= '0;
        end else if (busy_o) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    AST_LOAD_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && product_o == {{W{1'b0}}, $past(mplier_i)})); // R1
    AST_PRODUCT_OK: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (product_o == exp_q)); // R2
    AST_ITER_COUNT: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (run_cnt == CNW'(W))); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R4
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(product_o)); // R6
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && product_o == '0)); // R7

endmodule

bind seqmul_top mul_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
);

// File: tb/seqmul_tb.sv
`timescale 1ns/1ps
module seqmul_top_tb_top;
    localparam int unsigned W  = 32;
    localparam int unsigned SW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          start = 1'b0;
    logic [W-1:0]  mc = '0, mp = '0;
    logic          busy, done;
    logic [2*W-1:0] prod;

    logic           s_start = 1'b0;
    logic [SW-1:0]  s_mc = '0, s_mp = '0;
    logic           s_busy, s_done;
    logic [2*SW-1:0] s_prod;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    seqmul_top #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .mcand_i(mc), .mplier_i(mp),
        .busy_o(busy), .done_o(done), .product_o(prod)
    );

    seqmul_top #(.W(SW)) dut_s_i (
        .clk(clk), .rst(rst), .start_i(s_start), .mcand_i(s_mc), .mplier_i(s_mp),
        .busy_o(s_busy), .done_o(s_done), .product_o(s_prod)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic mul32(input logic [W-1:0] a, input logic [W-1:0] b, input bit jam, input string tag);
        logic [2*W-1:0] exp;
        exp = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        @(negedge clk);
        start = 1'b1; mc = a; mp = b;
        @(negedge clk);
        chk(busy && !done, "R1 busy after accept", {62'b0, busy, done}, 64'h2);
        chk(prod == {{W{1'b0}}, b}, "R1 load value", prod, {{W{1'b0}}, b});
        start = jam; mc = ~a; mp = b ^ 32'h5a5a_a5a5;
        repeat (W - 1) @(negedge clk);
        chk(busy && !done, "R3 busy through step W-1", {62'b0, busy, done}, 64'h2);
        @(negedge clk);
        start = 1'b0;
        chk(done && !busy, "R3 R4 done after W steps", {62'b0, busy, done}, 64'h1);
        chk(prod == exp, tag, prod, exp);
        mc = 32'hdead_beef; mp = 32'h0bad_f00d;
        @(negedge clk);
        chk(!done, "R4 done single cycle", {63'b0, done}, 64'h0);
        chk(prod == exp, "R6 hold after done", prod, exp);
        mc = 32'h1357_9bdf;
        repeat (2) @(negedge clk);
        chk(prod == exp && !busy, "R6 idle hold", prod, exp);
    endtask

    initial begin
        logic [2*W-1:0] e1;
        logic [2*W-1:0] e2;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && prod == '0, "R7 reset state", prod, 64'h0);
        rst = 1'b0;

        mul32(32'd0, 32'd0, 1'b0, "R2 zero by zero");
        mul32(32'd1, 32'hffff_ffff, 1'b0, "R2 one by max");
        mul32(32'd12345, 32'd6789, 1'b0, "R2 small values");
        mul32(32'hffff_ffff, 32'hffff_ffff, 1'b0, "R8 all-ones product");
        mul32(32'h8000_0000, 32'h8000_0000, 1'b0, "R8 top bits");
        mul32(32'hffff_ffff, 32'h0000_0002, 1'b0, "R8 carry into top");
        mul32(32'h1234_5678, 32'h9abc_def0, 1'b1, "R5 start ignored while busy");
        for (int i = 1; i <= 8; i++) begin
            mul32(32'h9e37_79b9 * i, 32'h7f4a_7c15 ^ (i << 9), 1'b0, "R2 pattern sweep");
        end

        // R9: back-to-back start in the done cycle
        e1 = 64'd3 * 64'd5;
        e2 = 64'h0000_0000_ffff_fffe * 64'd7;
        @(negedge clk);
        start = 1'b1; mc = 32'd3; mp = 32'd5;
        @(negedge clk);
        start = 1'b0;
        repeat (W) @(negedge clk);
        chk(done && prod == e1, "R9 first result", prod, e1);
        start = 1'b1; mc = 32'hffff_fffe; mp = 32'd7;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done && prod == 64'd7, "R9 second accepted in done cycle", prod, 64'd7);
        repeat (W) @(negedge clk);
        chk(done && prod == e2, "R9 second result", prod, e2);

        // R7: reset during an operation
        @(negedge clk);
        start = 1'b1; mc = 32'h0f0f_0f0f; mp = 32'hffff_0001;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!busy && !done && prod == '0, "R7 reset mid operation", prod, 64'h0);
        rst = 1'b0;
        @(negedge clk);

        // R2: exhaustive sweep on the narrow instance
        for (int a = 0; a < (1 << SW); a++) begin
            for (int b = 0; b < (1 << SW); b++) begin
                @(negedge clk);
                s_start = 1'b1; s_mc = SW'(a); s_mp = SW'(b);
                @(negedge clk);
                s_start = 1'b0;
                repeat (SW) @(negedge clk);
                chk(s_done && !s_busy && s_prod == 10'(a * b), "R2 R3 narrow exhaustive",
                    {54'b0, s_prod}, 64'(a * b));
            end
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule